// File: doc/BRIEF.md
# Subaddress-Mapped Message Bus Backend

This block sits between the message state machine of a serial-bus terminal and the user's logic. It turns the words that the state machine accepts into plain processor-style bus cycles. A data word that arrives for a receive message becomes a one-cycle write strobe. A word that the terminal must send becomes a one-cycle read strobe, and the fetched value is handed back to the state machine. The address of every cycle is formed from the direction and subaddress of the current command and the word's position within the message.

Once the state machine flags a message error, the block issues no further cycles until the next command arrives. Subaddress 30 is reserved for the wrap-around test. Words sent to it are stored in a 32 x 16 internal memory, and transmit requests on it are answered from that memory. Neither kind of access reaches the user bus.

Top module: `msgbus_backend`

## Requirements
- R1: After reset `mb_wr`, `mb_rd` and `tx_valid` are 0 and `mb_addr` is 0.
- R2: A `rx_valid` pulse inside a live receive message (`cmd_tr`=0) to a subaddress other than 30 gives exactly one `mb_wr` pulse, one cycle wide, in the cycle after the word, with `mb_dout` equal to `rx_data`.
- R3: A `tx_req` pulse inside a live transmit message (`cmd_tr`=1) to a subaddress other than 30 gives exactly one `mb_rd` pulse, one cycle wide, in the cycle after the request. In the following cycle `tx_valid` is 1 and `tx_data` holds the `mb_din` value sampled while `mb_rd` was high.
- R4: During each `mb_wr` or `mb_rd` pulse, `mb_addr` is formed as follows: bit 10 is the direction (1 = transmit), bits 9:5 are the command subaddress, bits 4:0 are the word index, and bits 15:11 are 0.
- R5: The word index is 0 for the first word after every `cmd_start`. It rises by one for each accepted word and wraps from 31 to 0.
- R6: After a `msg_error` pulse, no `mb_wr`, `mb_rd` or `tx_valid` is produced until the next `cmd_start`. A word presented in the same cycle as `msg_error` is dropped.
- R7: Words are ignored when no message is open, either before the first command or after `msg_end`. Words in the wrong direction are also ignored: `rx_valid` in a transmit message and `tx_req` in a receive message.
- R8: With subaddress 30, a received word is written to internal word [index] and produces no `mb_wr`. A transmit request produces no `mb_rd` and returns internal word [index] on `tx_data` with `tx_valid` two cycles after the request. The internal memory is cleared by reset.
- R9: When `cmd_start` and `msg_end` arrive in the same cycle, the new command opens and its words are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start | input | 1 | A new valid command word was accepted |
| cmd_tr | input | 1 | Direction of the command, 1 = terminal transmits |
| cmd_sa | input | 5 | Subaddress of the command |
| msg_end | input | 1 | Current message has ended |
| msg_error | input | 1 | Current message has failed |
| rx_valid | input | 1 | A valid data word was received |
| rx_data | input | 16 | Received data word |
| tx_req | input | 1 | Next word to transmit is requested |
| tx_valid | output | 1 | Fetched transmit word is ready |
| tx_data | output | 16 | Fetched transmit word |
| mb_addr | output | 16 | User bus address |
| mb_dout | output | 16 | User bus write data |
| mb_din | input | 16 | User bus read data, sampled during `mb_rd` |
| mb_wr | output | 1 | One-cycle write strobe |
| mb_rd | output | 1 | One-cycle read strobe |

## Verification
The assertions assume that `cmd_start` never shares a cycle with `rx_valid` or `tx_req`, and that the inputs are held low during reset. They also assume that `mb_din` is valid in the cycle `mb_rd` is high. The stimulus tasks drive one event per transaction and never combine a command with a word. The bench's user-bus model returns data derived combinationally from `mb_addr`. Random sequences mix commands, errors, message ends and words in both directions, with subaddress 30 chosen often.

// File: rtl/msgbus_backend.sv
module msgbus_backend #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int SA_W    = 5,
  parameter int IDX_W   = 5,
  parameter int LOOP_SA = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_tr,
  input  logic [SA_W-1:0]   cmd_sa,
  input  logic              msg_end,
  input  logic              msg_error,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [ADDR_W-1:0] mb_addr,
  output logic [DATA_W-1:0] mb_dout,
  input  logic [DATA_W-1:0] mb_din,
  output logic              mb_wr,
  output logic              mb_rd
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int FIELD_W = 1 + SA_W + IDX_W;

  logic              active, aborted, cur_tr, lb_rd;
  logic [SA_W-1:0]   cur_sa;
  logic [IDX_W-1:0]  idx, lb_idx;
  logic [DATA_W-1:0] lb_mem [DEPTH];

  wire live    = active & ~aborted & ~msg_error;
  wire go_wr   = live & ~cur_tr & rx_valid;
  wire go_rd   = live &  cur_tr & tx_req;
  wire is_loop = (cur_sa == SA_W'(LOOP_SA));
  wire [FIELD_W-1:0] field = {cur_tr, cur_sa, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      aborted <= 1'b0;
      cur_tr  <= 1'b0;
      cur_sa  <= '0;
      idx     <= '0;
    end else if (cmd_start) begin
      active  <= 1'b1;
      aborted <= 1'b0;
      cur_tr  <= cmd_tr;
      cur_sa  <= cmd_sa;
      idx     <= '0;
    end else begin
      if (msg_end)       active  <= 1'b0;
      if (msg_error)     aborted <= 1'b1;
      if (go_wr | go_rd) idx     <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_wr    <= 1'b0;
      mb_rd    <= 1'b0;
      lb_rd    <= 1'b0;
      lb_idx   <= '0;
      mb_addr  <= '0;
      mb_dout  <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      mb_wr    <= go_wr & ~is_loop;
      mb_rd    <= go_rd & ~is_loop;
      lb_rd    <= go_rd &  is_loop;
      tx_valid <= mb_rd | lb_rd;
      if (go_wr | go_rd) begin
        mb_addr <= ADDR_W'(field);
        lb_idx  <= idx;
      end
      if (go_wr)      mb_dout <= rx_data;
      if (mb_rd)      tx_data <= mb_din;
      else if (lb_rd) tx_data <= lb_mem[lb_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lb_mem[i] <= '0;
    end else if (go_wr & is_loop) begin
      lb_mem[idx] <= rx_data;
    end
  end
endmodule

module msgbus_backend_chk #(
  parameter int SA_W  = 5,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             rx_valid,
  input logic             tx_req,
  input logic             tx_valid,
  input logic [15:0]      mb_addr,
  input logic             mb_wr,
  input logic             mb_rd,
  input logic             aborted,
  input logic [IDX_W-1:0] idx
);
  p_wr_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |-> $past(rx_valid));
  p_rd_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |-> $past(tx_req));
  p_rd_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |=> tx_valid);
  p_wr_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |-> !mb_addr[SA_W+IDX_W]);
  p_rd_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |-> mb_addr[SA_W+IDX_W]);
  p_idx_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> idx == '0);
  p_quiet_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |=> !mb_wr && !mb_rd);
  p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_wr && mb_rd));
endmodule

bind msgbus_backend msgbus_backend_chk u_chk (.*);

// File: tb/test_msgbus_backend.sv
`timescale 1ns/1ps
module test_msgbus_backend;
  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_tr = 0, msg_end = 0, msg_error = 0;
  logic rx_valid = 0, tx_req = 0;
  logic [4:0] cmd_sa = 0;
  logic [15:0] rx_data = 0;
  logic tx_valid, mb_wr, mb_rd;
  logic [15:0] tx_data, mb_addr, mb_dout, mb_din;
  int checks = 0, errors = 0;

  logic m_active = 0, m_abort = 0, m_tr = 0;
  logic [4:0] m_sa = 0, m_idx = 0;
  logic [15:0] m_mem [32];

  always #4 clk = ~clk;

  function automatic logic [15:0] ext_data(input logic [15:0] a);
    return a * 16'h9E37 + 16'h1234;
  endfunction
  assign mb_din = ext_data(mb_addr);

  msgbus_backend i_msgbus_backend (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic tr, input logic [4:0] sa, input logic with_end);
    @(negedge clk);
    cmd_start = 1; cmd_tr = tr; cmd_sa = sa; msg_end = with_end;
    @(negedge clk);
    cmd_start = 0; msg_end = 0;
    m_active = 1; m_abort = 0; m_tr = tr; m_sa = sa; m_idx = 0;
  endtask

  task automatic do_end();
    @(negedge clk); msg_end = 1;
    @(negedge clk); msg_end = 0;
    m_active = 0;
  endtask

  task automatic do_err(input logic with_word);
    @(negedge clk); msg_error = 1; rx_valid = with_word; rx_data = 16'hDEAD;
    @(negedge clk); msg_error = 0; rx_valid = 0;
    chk(!mb_wr, "R6 word with error", mb_wr, 0);
    m_abort = 1;
  endtask

  task automatic do_rx(input logic [15:0] w);
    bit go = m_active && !m_abort && !m_tr;
    bit lp = (m_sa == 5'd30);
    logic [15:0] ea = {5'b0, m_tr, m_sa, m_idx};
    @(negedge clk); rx_valid = 1; rx_data = w;
    @(negedge clk); rx_valid = 0;
    chk(mb_wr == (go && !lp), go ? (lp ? "R8 no write" : "R2 write") : "R7/R6 ignored rx", mb_wr, go && !lp);
    if (go && !lp) begin
      chk(mb_addr == ea, "R4/R5 write addr", mb_addr, ea);
      chk(mb_dout == w, "R2 write data", mb_dout, w);
    end
    @(negedge clk);
    chk(!mb_wr, "R2 single pulse", mb_wr, 0);
    if (go) begin
      if (lp) m_mem[m_idx] = w;
      m_idx++;
    end
  endtask

  task automatic do_tx();
    bit go = m_active && !m_abort && m_tr;
    bit lp = (m_sa == 5'd30);
    logic [15:0] ea = {5'b0, m_tr, m_sa, m_idx};
    logic [15:0] ed = lp ? m_mem[m_idx] : ext_data(ea);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
    chk(mb_rd == (go && !lp), go ? (lp ? "R8 no read" : "R3 read") : "R7/R6 ignored tx", mb_rd, go && !lp);
    if (go && !lp) chk(mb_addr == ea, "R4/R5 read addr", mb_addr, ea);
    @(negedge clk);
    chk(!mb_rd, "R3 single pulse", mb_rd, 0);
    chk(tx_valid == go, go ? "R3/R8 tx valid" : "R6/R7 no tx valid", tx_valid, go);
    if (go) begin
      chk(tx_data == ed, lp ? "R8 loop data" : "R3 fetched data", tx_data, ed);
      m_idx++;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1553));
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(!mb_wr && !mb_rd && !tx_valid, "R1 strobes after reset", {mb_wr, mb_rd, tx_valid}, 0);
    chk(mb_addr == 0, "R1 addr after reset", mb_addr, 0);
    rst_n = 1;
    do_rx(16'h1111);                       // R7 before any command
    do_tx();
    do_cmd(0, 5'd3, 0);
    do_rx(16'hA001); do_rx(16'hA002);
    do_tx();                               // R7 wrong direction
    do_end();
    do_rx(16'hA003);                       // R7 after end
    do_cmd(1, 5'd7, 0);
    do_tx(); do_tx(); do_rx(16'h5555);
    do_err(0);                             // R6
    do_tx();
    do_cmd(0, 5'd9, 0);
    do_rx(16'h0F0F);
    do_err(1);                             // R6 same cycle
    do_rx(16'h0F10);
    do_cmd(0, 5'd5, 0);                    // R5 wrap
    for (int i = 0; i < 34; i++) do_rx(16'h7000 + 16'(i));
    do_cmd(0, 5'd30, 0);                   // R8 loop-back fill
    for (int i = 0; i < 32; i++) do_rx(16'hC000 ^ 16'(i * 97));
    do_cmd(1, 5'd30, 0);
    for (int i = 0; i < 33; i++) do_tx();
    do_cmd(0, 5'd12, 1);                   // R9 start with end
    do_rx(16'hBEEF);
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 10;
      if (op == 0)
        do_cmd(1'($urandom), ($urandom % 4 == 0) ? 5'd30 : 5'($urandom), 0);
      else if (op == 1) do_err(1'($urandom));
      else if (op == 2) do_end();
      else if (op < 6)  do_rx(16'($urandom));
      else              do_tx();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule